// File: doc/BRIEF.md
# Burst SRAM Address Sequencer

This block produces the word address for a burst-capable synchronous SRAM. An address-status strobe on a rising clock edge captures an external start address. After that, each rising edge with the active-low advance input held low steps a two-bit burst position. The bits above the low two are held at their captured value for the whole burst. The low two bits follow one of two orders: counting up modulo four (linear), or the start value XORed with the position (interleaved). A mode input picks the order.

There are two strobes. The processor-side strobe is qualified by a chip-enable input. The cache-controller-side strobe always loads. Either strobe takes precedence over advance and restarts the burst at position zero. While advance is high, the address and the position hold for any number of cycles. The address width is a parameter: 18 bits for the deeper configuration and 17 bits for the shallower one.

Top module: `burst_addr_seq`

## Requirements
- R1: When a load occurs on a rising edge, after that edge `addr_out` equals the `addr_in` value sampled at that edge and `burst_pos` is 0.
- R2: `strobe_cpu` causes a load only when `chip_en` is 1. While `chip_en` is 0 it has no effect, and the advance rule applies as if it were low. `strobe_ctl` causes a load regardless of `chip_en`.
- R3: With no load, an edge where `adv_n` is 0 increments `burst_pos` by one, modulo 4.
- R4: With no load, an edge where `adv_n` is 1 leaves `burst_pos` and `addr_out` unchanged.
- R5: When `order_sel` is 0 (linear), `addr_out[1:0]` equals (captured low bits + `burst_pos`) mod 4. A start of 2 gives 2, 3, 0, 1.
- R6: When `order_sel` is 1 (interleaved), `addr_out[1:0]` equals the captured low bits XOR `burst_pos`. A start of 1 gives 1, 0, 3, 2.
- R7: `addr_out[ADDR_W-1:2]` changes only on a load. After the fourth beat, further advancing returns to the start address, with no carry into the upper bits.
- R8: A load on the same edge as `adv_n` = 0 takes priority and gives `burst_pos` = 0.
- R9: A rising edge with `rst` high sets `addr_out` to 0 and `burst_pos` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe_cpu | input | 1 | Processor-side address strobe, qualified by chip_en |
| strobe_ctl | input | 1 | Cache-controller-side address strobe, unqualified |
| chip_en | input | 1 | Enable qualifier for strobe_cpu |
| adv_n | input | 1 | Active-low burst advance |
| order_sel | input | 1 | 0 selects linear order, 1 selects interleaved order |
| addr_in | input | ADDR_W | External start address |
| addr_out | output | ADDR_W | Current array word address |
| burst_pos | output | 2 | Beat index within the burst, 0 to 3 |

## Verification
A strobe and a low advance input can arrive on the same edge. The same is true of a processor strobe and an inactive chip enable, and there the advance rule alone must apply. The bench raises both conditions on purpose, mid-burst, and also scatters them through a long pseudo-random stretch. On every cycle a behavioural model predicts the position and the address, and each mismatch is charged to the event the model saw at that edge: priority restart, gated strobe, step or hold.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int POS_W = 2;

    typedef logic [POS_W-1:0] beat_t;

    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_XOR    = 1'b1
    } burst_order_e;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_STEP = 2'd1,
        ACT_LOAD = 2'd2
    } seq_act_e;

    // Low address bits for a given start value and beat index.
    function automatic beat_t order_beat(beat_t base, beat_t pos, burst_order_e ord);
        beat_t r;
        if (ord == ORD_XOR) r = base ^ pos;
        else                r = beat_t'(base + pos);
        return r;
    endfunction

endpackage

// File: rtl/burst_load_ctl.sv
module burst_load_ctl
    import burst_seq_pkg::*;
(
    input  logic     strobe_cpu,
    input  logic     strobe_ctl,
    input  logic     chip_en,
    input  logic     adv_n,
    output seq_act_e act
);

    logic cpu_ok;

    always_comb begin
        cpu_ok = strobe_cpu & chip_en;
        if (strobe_ctl || cpu_ok) act = ACT_LOAD;
        else if (!adv_n)          act = ACT_STEP;
        else                      act = ACT_HOLD;
    end

endmodule

// File: rtl/burst_pos_counter.sv
module burst_pos_counter
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 18,
    localparam int UP_W  = ADDR_W - POS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_act_e          act,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [UP_W-1:0]   upper,
    output beat_t             base,
    output beat_t             pos
);

    always_ff @(posedge clk) begin
        if (rst) begin
            upper <= '0;
            base  <= '0;
            pos   <= '0;
        end else begin
            case (act)
                ACT_LOAD: begin
                    upper <= addr_in[ADDR_W-1:POS_W];
                    base  <= addr_in[POS_W-1:0];
                    pos   <= '0;
                end
                ACT_STEP: pos <= beat_t'(pos + 1'b1);
                default:  ;
            endcase
        end
    end

    AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (rst)
        act == ACT_LOAD |=> pos == '0); // R8
    AST_STEP_INC: assert property (@(posedge clk) disable iff (rst)
        act == ACT_STEP |=> pos == beat_t'($past(pos) + 1'b1)); // R3
    AST_HOLD_POS: assert property (@(posedge clk) disable iff (rst)
        act == ACT_HOLD |=> $stable(pos) && $stable(base)); // R4
    AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (rst)
        act != ACT_LOAD |=> $stable(upper)); // R7
    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        act == ACT_LOAD |=> upper == $past(addr_in[ADDR_W-1:POS_W])); // R1

endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 18,
    localparam int UP_W  = ADDR_W - POS_W
) (
    input  logic [UP_W-1:0]   upper,
    input  beat_t             base,
    input  beat_t             pos,
    input  burst_order_e      ord,
    output logic [ADDR_W-1:0] addr_out
);

    beat_t low;

    always_comb begin
        low      = order_beat(base, pos, ord);
        addr_out = {upper, low};
    end

    always_comb begin
        if (pos == '0 && ord == ORD_LINEAR)
            AST_FIRST_BEAT_LIN: assert (low == base); // R5
        if (pos == '0 && ord == ORD_XOR)
            AST_FIRST_BEAT_XOR: assert (low == base); // R6
    end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 18,
    localparam int UP_W  = ADDR_W - POS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe_cpu,
    input  logic              strobe_ctl,
    input  logic              chip_en,
    input  logic              adv_n,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic [1:0]        burst_pos
);

    seq_act_e        act;
    logic [UP_W-1:0] upper;
    beat_t           base;
    beat_t           pos;
    burst_order_e    ord;

    assign ord       = burst_order_e'(order_sel);
    assign burst_pos = pos;

    burst_load_ctl u_ctl (
        .strobe_cpu (strobe_cpu),
        .strobe_ctl (strobe_ctl),
        .chip_en    (chip_en),
        .adv_n      (adv_n),
        .act        (act)
    );

    burst_pos_counter #(.ADDR_W(ADDR_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .act     (act),
        .addr_in (addr_in),
        .upper   (upper),
        .base    (base),
        .pos     (pos)
    );

    burst_addr_map #(.ADDR_W(ADDR_W)) u_map (
        .upper    (upper),
        .base     (base),
        .pos      (pos),
        .ord      (ord),
        .addr_out (addr_out)
    );

    AST_CPU_GATED: assert property (@(posedge clk) disable iff (rst)
        (strobe_cpu && !chip_en && !strobe_ctl) |=> $stable(addr_out[ADDR_W-1:POS_W])); // R2
    AST_CTL_LOADS: assert property (@(posedge clk) disable iff (rst)
        strobe_ctl |=> burst_pos == 2'd0); // R2
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> addr_out == '0 && burst_pos == 2'd0); // R9

endmodule

// File: tb/tb_burst_addr_seq.sv
module tb_burst_addr_seq;

    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          strobe_cpu = 1'b0, strobe_ctl = 1'b0, chip_en = 1'b0;
    logic          adv_n = 1'b1, order_sel = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] addr_out;
    logic [1:0]    burst_pos;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    int    m_up = 0, m_base = 0, m_pos = 0;
    string m_tag = "R9";

    always #5 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .strobe_cpu(strobe_cpu), .strobe_ctl(strobe_ctl),
        .chip_en(chip_en), .adv_n(adv_n), .order_sel(order_sel),
        .addr_in(addr_in), .addr_out(addr_out), .burst_pos(burst_pos)
    );

    always @(posedge clk) begin
        bit ld;
        ld = strobe_ctl || (strobe_cpu && chip_en);
        if (rst) begin
            m_up = 0; m_base = 0; m_pos = 0; m_tag = "R9";
        end else if (ld) begin
            m_up   = int'(addr_in) >> 2;
            m_base = int'(addr_in) & 3;
            m_pos  = 0;
            m_tag  = !adv_n ? "R8" : (!chip_en ? "R2" : "R1");
        end else begin
            if (!adv_n) m_pos = (m_pos + 1) % 4;
            if (strobe_cpu && !chip_en) m_tag = "R2";
            else m_tag = !adv_n ? "R3" : "R4";
        end
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare();
        int lo;
        lo = order_sel ? (m_base ^ m_pos) : ((m_base + m_pos) % 4);
        check(m_tag, int'(burst_pos), m_pos);
        check(m_tag == "R4" ? "R4" : "R7", int'(addr_out) >> 2, m_up);
        check(order_sel ? "R6" : "R5", int'(addr_out) & 3, lo);
    endtask

    task automatic step(bit cpu, bit ctl, bit ce, bit an, bit il, int a);
        @(negedge clk);
        compare();
        strobe_cpu = cpu; strobe_ctl = ctl; chip_en = ce;
        adv_n = an; order_sel = il; addr_in = AW'(a);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        // R9: reset state
        step(0, 0, 0, 1, 0, 0);
        step(0, 0, 0, 1, 0, 'h15);
        rst = 1'b0;
        // R1 / R5 / R7: linear start 2, wrap after four beats
        step(1, 0, 1, 1, 0, 'h2A);
        for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 0, 0);
        // R6: interleaved start 1
        step(0, 1, 1, 1, 1, 'h1D);
        for (int i = 0; i < 5; i++) step(0, 0, 1, 0, 1, 0);
        // R4: hold
        for (int i = 0; i < 4; i++) step(0, 0, 1, 1, 1, 'h3);
        // R2: gated cpu strobe, then ungated controller strobe
        step(1, 0, 0, 1, 0, 'h1234);
        step(1, 0, 0, 0, 0, 'h1234);
        step(0, 1, 0, 1, 0, 'h2345);
        step(0, 0, 0, 0, 0, 0);
        // R8: strobe with advance mid-burst
        step(0, 0, 1, 0, 0, 0);
        step(1, 0, 1, 0, 0, 'h0777);
        step(0, 1, 0, 0, 1, 'h0A5A);
        // R7: top of range, no carry
        step(0, 1, 1, 1, 0, 'h3FFFF);
        for (int i = 0; i < 6; i++) step(0, 0, 1, 0, 0, 0);
        // R3 etc: pseudo-random stretch with mode flips
        for (int i = 0; i < 400; i++) begin
            int r;
            r = $urandom;
            step(r[3:0] == 0, r[7:4] == 0, r[8], r[9] & r[10], r[11], r[29:12]);
        end
        // R9: reset mid-burst
        rst = 1'b1;
        step(0, 0, 1, 0, 0, 0);
        rst = 1'b0;
        step(0, 0, 1, 1, 0, 0);
        step(0, 0, 1, 1, 0, 0);
        finish_run();
    end

endmodule